// File: doc/BRIEF.md
# GPIO Register Bank with Polarity Inversion

This block holds the control and status registers of a general-purpose parallel I/O port. A 2-bit pointer selects one of four registers: the sampled pin levels, the drive value, a per-bit inversion mask and a per-bit direction mask. A write strobe with data updates the selected register on the next clock edge. Read data for the selected register is returned combinationally from the pointer, the stored registers and the live pin levels.

Toward the pad ring the block presents an output-enable vector and an output-value vector. A direction bit of 1 makes its pin an input, so the enable for that pin is off. A direction bit of 0 enables the driver with the matching bit of the drive register. The pin-level register cannot be written. Its read value is the pins exclusive-ORed with the inversion mask, whatever the direction of each pin. The pad electrical behaviour and the serial bus that carries the accesses are outside this block.

Top module: `gpio_regbank`

## Requirements
- R1: Pointer encoding: 0 selects the pin-level register, 1 the drive register, 2 the inversion mask and 3 the direction mask. `rd_data` returns the register selected by `reg_sel`.
- R2: A write with `reg_sel` = 0 changes no register, so `pad_oe`, `pad_out` and the read values of pointers 1, 2 and 3 stay as they were.
- R3: A read of pointer 0 returns `pin_in` XOR inversion mask in the same cycle. A mask bit of 1 inverts its pin and a mask bit of 0 passes it unchanged.
- R4: R3 holds for every pin, whether the direction mask makes it an input or an output.
- R5: For each bit, `pad_oe[i]` = NOT direction bit i. A direction bit of 1 (input) turns the driver off, and a direction bit of 0 (output) turns it on.
- R6: `pad_out[i]` equals drive-register bit i. A read of pointer 1 returns the stored drive value and not the pin level.
- R7: After reset the drive register is all ones, the inversion mask is all zeros and the direction mask is all ones. So `pad_oe` is all zeros and `pad_out` is all ones.
- R8: A write takes effect on the rising clock edge that samples `wr_en` high. Before that edge, the read data and pad outputs show the old value.
- R9: A write changes only the register that `reg_sel` selects. With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register pointer (0 pins, 1 drive, 2 inversion, 3 direction) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data of the selected register |
| pin_in | input | WIDTH | Live pin levels from the pads |
| pad_oe | output | WIDTH | Per-pin driver enable, 1 = drive |
| pad_out | output | WIDTH | Per-pin driven value |

## Verification
Read data is combinational from the pointer and the pin levels. The bench therefore changes `reg_sel` or `pin_in` on a falling edge and compares `rd_data` one time unit later, in the same half cycle. A write is presented on a falling edge and lands on the next rising edge, so stored values and pad outputs are checked at the following falling edge. The old value is also checked before that rising edge to pin the one-cycle latency down. The bound checker checks the same one-edge latency with `|=>` properties on the pad outputs and on the read-back.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
   typedef enum logic [1:0] {
      PTR_PINS  = 2'd0,
      PTR_DRIVE = 2'd1,
      PTR_FLIP  = 2'd2,
      PTR_DIR   = 2'd3
   } reg_ptr_e;

   localparam int unsigned PTR_W = 2;
endpackage

// File: rtl/gpio_regbank_store.sv
module gpio_regbank_store
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  reg_ptr_e         ptr,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] drive_q,
   output logic [WIDTH-1:0] flip_q,
   output logic [WIDTH-1:0] dir_q
);
   localparam logic [WIDTH-1:0] DRIVE_RST = '1;
   localparam logic [WIDTH-1:0] FLIP_RST  = '0;
   localparam logic [WIDTH-1:0] DIR_RST   = '1;

   logic wr_drive, wr_flip, wr_dir;

   always_comb begin
      wr_drive = wr_en && (ptr == PTR_DRIVE);
      wr_flip  = wr_en && (ptr == PTR_FLIP);
      wr_dir   = wr_en && (ptr == PTR_DIR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= DRIVE_RST;
         flip_q  <= FLIP_RST;
         dir_q   <= DIR_RST;
      end else begin
         if (wr_drive) drive_q <= wr_data;
         if (wr_flip)  flip_q  <= wr_data;
         if (wr_dir)   dir_q   <= wr_data;
      end
   end
endmodule

// File: rtl/gpio_regbank_pinslice.sv
module gpio_regbank_pinslice (
   input  logic dir_bit,
   input  logic drive_bit,
   input  logic flip_bit,
   input  logic pin_bit,
   output logic oe_bit,
   output logic out_bit,
   output logic seen_bit
);
   always_comb begin
      oe_bit   = ~dir_bit;
      out_bit  = drive_bit;
      seen_bit = pin_bit ^ flip_bit;
   end
endmodule

// File: rtl/gpio_regbank_rdmux.sv
module gpio_regbank_rdmux
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  reg_ptr_e         ptr,
   input  logic [WIDTH-1:0] seen,
   input  logic [WIDTH-1:0] drive_q,
   input  logic [WIDTH-1:0] flip_q,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] rd_data
);
   always_comb begin
      unique case (ptr)
         PTR_PINS:  rd_data = seen;
         PTR_DRIVE: rd_data = drive_q;
         PTR_FLIP:  rd_data = flip_q;
         PTR_DIR:   rd_data = dir_q;
         default:   rd_data = seen;
      endcase
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_sel,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out
);
   initial begin
      if (WIDTH < 1 || WIDTH > 1024)
         $error("gpio_regbank: WIDTH %0d out of range 1..1024", WIDTH);
   end

   reg_ptr_e         ptr;
   logic [WIDTH-1:0] drive_q, flip_q, dir_q, seen;

   assign ptr = reg_ptr_e'(reg_sel);

   gpio_regbank_store #(.WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr     (ptr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .drive_q (drive_q),
      .flip_q  (flip_q),
      .dir_q   (dir_q)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      gpio_regbank_pinslice u_slice (
         .dir_bit   (dir_q[i]),
         .drive_bit (drive_q[i]),
         .flip_bit  (flip_q[i]),
         .pin_bit   (pin_in[i]),
         .oe_bit    (pad_oe[i]),
         .out_bit   (pad_out[i]),
         .seen_bit  (seen[i])
      );
   end

   gpio_regbank_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .ptr     (ptr),
      .seen    (seen),
      .drive_q (drive_q),
      .flip_q  (flip_q),
      .dir_q   (dir_q),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_sel,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out
);
   // R7: first sampled cycle after reset release shows defaults
   p_reset_pads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '1));

   // R5, R8: direction write shows on enables after one edge
   p_dir_to_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd3) |=> (pad_oe == ~$past(wr_data)));

   // R6, R8: drive write shows on pad_out after one edge
   p_drive_to_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1) |=> (pad_out == $past(wr_data)));

   // R2: writes to pointer 0 leave pads untouched
   p_pins_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd0) |=> ($stable(pad_oe) && $stable(pad_out)));

   // R9: no strobe, no change at the pads
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));

   // R3: new mask applies to pin reads from the next cycle
   p_flip_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd2) |=>
         ((reg_sel != 2'd0) || (rd_data == (pin_in ^ $past(wr_data)))));

   // R1: direction register read-back
   p_dir_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd3) |=>
         ((reg_sel != 2'd3) || (rd_data == $past(wr_data))));
endmodule

bind gpio_regbank gpio_regbank_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_sel (reg_sel),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pin_in  (pin_in),
   .pad_oe  (pad_oe),
   .pad_out (pad_out)
);

// File: tb/gpio_regbank_test.sv
module gpio_regbank_test;
   localparam int  WIDTH = 8;
   localparam time CLK_PERIOD = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       reg_sel = 2'd0;
   logic             wr_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic [WIDTH-1:0] pin_in = '0;
   logic [WIDTH-1:0] rd_data, pad_oe, pad_out;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_regbank #(.WIDTH(WIDTH)) uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [WIDTH-1:0] data);
      @(negedge clk);
      reg_sel = sel; wr_data = data; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] sel, logic [WIDTH-1:0] exp, string tag);
      reg_sel = sel;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic t_reset_r7();
      rd(2'd1, 8'hFF, "R7 drive default");
      rd(2'd2, 8'h00, "R7 flip default");
      rd(2'd3, 8'hFF, "R7 dir default");
      check("R7 pad_oe default", pad_oe, 8'h00);
      check("R7 pad_out default", pad_out, 8'hFF);
   endtask

   task automatic t_decode_r1();
      wr(2'd1, 8'h5A);
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'hC3);
      pin_in = 8'h00;
      rd(2'd0, 8'h0F, "R1 ptr0 pins");
      rd(2'd1, 8'h5A, "R1 ptr1 drive");
      rd(2'd2, 8'h0F, "R1 ptr2 flip");
      rd(2'd3, 8'hC3, "R1 ptr3 dir");
   endtask

   task automatic t_pins_write_r2();
      logic [WIDTH-1:0] oe0, out0;
      oe0 = pad_oe; out0 = pad_out;
      wr(2'd0, 8'h33);
      check("R2 pad_oe", pad_oe, oe0);
      check("R2 pad_out", pad_out, out0);
      rd(2'd1, 8'h5A, "R2 drive kept");
      rd(2'd2, 8'h0F, "R2 flip kept");
      rd(2'd3, 8'hC3, "R2 dir kept");
   endtask

   task automatic t_invert_r3();
      wr(2'd2, 8'hA5);
      pin_in = 8'h3C; rd(2'd0, 8'h99, "R3 pins^mask a");
      pin_in = 8'hFF; rd(2'd0, 8'h5A, "R3 pins^mask b");
      wr(2'd2, 8'h00);
      pin_in = 8'h6D; rd(2'd0, 8'h6D, "R3 zero mask pass");
   endtask

   task automatic t_outputs_read_r4();
      wr(2'd3, 8'h00);
      wr(2'd2, 8'hF0);
      pin_in = 8'h12; rd(2'd0, 8'hE2, "R4 all outputs read pins");
      wr(2'd3, 8'h0F);
      pin_in = 8'h81; rd(2'd0, 8'h71, "R4 mixed dir read pins");
   endtask

   task automatic t_direction_r5();
      wr(2'd3, 8'hF0); check("R5 oe mixed", pad_oe, 8'h0F);
      wr(2'd3, 8'h00); check("R5 oe all out", pad_oe, 8'hFF);
      wr(2'd3, 8'hFF); check("R5 oe all in", pad_oe, 8'h00);
   endtask

   task automatic t_drive_r6();
      wr(2'd1, 8'h96);
      check("R6 pad_out", pad_out, 8'h96);
      pin_in = 8'h00; rd(2'd1, 8'h96, "R6 drive readback not pin");
      pin_in = 8'hFF; rd(2'd1, 8'h96, "R6 drive readback not pin b");
   endtask

   task automatic t_latency_r8();
      @(negedge clk);
      reg_sel = 2'd1; wr_data = 8'h3E; wr_en = 1'b1;
      #1;
      check("R8 old read before edge", rd_data, 8'h96);
      check("R8 old pad_out before edge", pad_out, 8'h96);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check("R8 new read after edge", rd_data, 8'h3E);
      check("R8 new pad_out after edge", pad_out, 8'h3E);
   endtask

   task automatic t_isolation_r9();
      wr(2'd2, 8'h11);
      rd(2'd1, 8'h3E, "R9 drive untouched by flip wr");
      rd(2'd3, 8'hFF, "R9 dir untouched by flip wr");
      @(negedge clk);
      reg_sel = 2'd1; wr_data = 8'h00; wr_en = 1'b0;
      @(negedge clk);
      check("R9 no strobe no change", pad_out, 8'h3E);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r7();
      t_decode_r1();
      t_pins_write_r2();
      t_invert_r3();
      t_outputs_read_r4();
      t_direction_r5();
      t_drive_r6();
      t_latency_r8();
      t_isolation_r9();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule